// File: doc/BRIEF.md
# Supply Low-Voltage Detect Controller

This block is the digital side of a supply low-voltage detector. It holds one 8-bit control and status register. Software can write it as a whole byte or one bit at a time. The block takes the output of an analog comparator that reports whether the supply is below the detection threshold. It passes that bit through a two-stage synchronizer and publishes it as a detection flag.

Depending on a mode bit, a low supply raises either a level interrupt or a pulsed internal reset request. The pulse is meant for the system reset controller. A settling timer starts each time the detector is enabled. No request of either kind leaves the block until the comparator has had time to stabilise. The settling time is `CLK_MHZ * SETTLE_US` cycles.

The system reset controller reports the cause of each reset on a dedicated input. A reset that this detector caused keeps the enable and mode bits. Every other reset clears them. After such a reset the settling timer starts over, so the detector cannot hold the system in a reset loop.

Top module: `lvd_ctrl`

## Requirements
- R1: After a reset whose cause is not this detector, `rdata` reads 0x00 and `irq_req`, `rst_req` and `ready` are all 0.
- R2: Register layout: bit 7 is the enable, bit 1 is the mode (0 = interrupt, 1 = reset) and bit 0 is the detection flag. Bits 6..2 always read 0. Writes to bit 0 or to bits 6..2 have no effect.
- R3: While the enable is 0, the flag reads 0 whatever the comparator input is.
- R4: While the enable is 1, the flag equals the comparator input delayed by two clock edges (1 = supply below threshold).
- R5: `ready` rises exactly `SETTLE_CYC` edges after the edge that sets the enable. It falls at the edge that clears the enable.
- R6: With enable=1, mode=0 and `ready`=1, `irq_req` equals the synchronized comparator level. With mode=1, `irq_req` is 0.
- R7: With enable=1, mode=1 and `ready`=1, a low supply starts an `rst_req` pulse at the next edge. The pulse stays high for exactly `RST_PULSE` cycles.
- R8: Neither `irq_req` nor `rst_req` is ever 1 while `ready` is 0. This includes the settling time after a detector-caused reset.
- R9: A reset with `rst_by_lvd`=1 keeps the enable and mode bits. A reset with `rst_by_lvd`=0 clears them.
- R10: A single-bit write (`bit_sel` 7 or 1) changes only the bit it selects. Clearing the enable while mode=1 produces no `rst_req` pulse.
- R11: A byte write of 0x00 makes `rdata`=0x00 and drops `irq_req`, `rst_req` and `ready` at the very next edge. This aborts any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_by_lvd | input | 1 | Reset cause, held during reset: 1 means this detector caused the reset |
| wr_byte | input | 1 | Byte write strobe; has priority over `wr_bit` |
| wdata | input | 8 | Byte write data |
| wr_bit | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Bit index for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rdata | output | 8 | Register read value |
| cmp_below | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| irq_req | output | 1 | Level interrupt request |
| rst_req | output | 1 | Internal reset request pulse |
| ready | output | 1 | Comparator settling time has elapsed |

## Verification
A wrong enable or mode bit shows on `rdata` at the first edge after the write. A settling counter that is off by one shifts the rise of `ready` and the first `irq_req` by one cycle, so the bench samples both on the exact cycle. A faulty pulse counter shows as an `rst_req` that is shorter, longer or late relative to the cycle that follows `ready`. A wrong reset-cause decision shows on `rdata` as soon as reset is released.

// File: rtl/lvd_ctrl.sv
module lvd_ctrl #(
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_US = 10,
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_by_lvd,
  input  logic       wr_byte,
  input  logic [7:0] wdata,
  input  logic       wr_bit,
  input  logic [2:0] bit_sel,
  input  logic       bit_val,
  output logic [7:0] rdata,
  input  logic       cmp_below,
  output logic       irq_req,
  output logic       rst_req,
  output logic       ready
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic          en, mode;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          below;

  assign below = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if (!rst_by_lvd) begin
        en   <= 1'b0;
        mode <= 1'b0;
      end
    end else if (wr_byte) begin
      en   <= wdata[7];
      mode <= wdata[1];
    end else if (wr_bit) begin
      if (bit_sel == 3'd7) en   <= bit_val;
      if (bit_sel == 3'd1) mode <= bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], cmp_below};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (!ready) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pcnt <= '0;
    else if (!en)                       pcnt <= '0;
    else if (pcnt != '0)                pcnt <= pcnt - 1'b1;
    else if (ready && mode && below)    pcnt <= PW'(RST_PULSE);
  end

  assign ready   = en && (cnt == CW'(SETTLE_CYC));
  assign rdata   = {en, 5'b00000, mode, en & below};
  assign irq_req = ready & ~mode & below;
  assign rst_req = en & (pcnt != '0);
endmodule

module lvd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_byte,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_req,
  input logic       rst_req,
  input logic       ready
);
  p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:2] == 5'b00000);
  p_flag_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[7] |-> !rdata[0]);
  p_irq_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (rdata[7] && !rdata[1] && rdata[0]));
  p_rst_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rdata[7] && rdata[1] && !irq_req));
  p_irq_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ready);
  p_rst_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ready);
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte && wdata == 8'h00) |=> (rdata == 8'h00 && !irq_req && !rst_req && !ready));
endmodule

bind lvd_ctrl lvd_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .wdata(wdata),
  .rdata(rdata), .irq_req(irq_req), .rst_req(rst_req), .ready(ready)
);

// File: tb/lvd_ctrl_tb_top.sv
module lvd_ctrl_tb_top;
  localparam int MHZ = 1, US = 4, S = MHZ * US, P = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_by_lvd = 1'b0;
  logic wr_byte = 1'b0, wr_bit = 1'b0, bit_val = 1'b0, cmp_below = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] bit_sel = 3'd0;
  logic [7:0] rdata;
  logic irq_req, rst_req, ready;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lvd_ctrl #(.CLK_MHZ(MHZ), .SETTLE_US(US), .RST_PULSE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_by_lvd(rst_by_lvd), .wr_byte(wr_byte),
    .wdata(wdata), .wr_bit(wr_bit), .bit_sel(bit_sel), .bit_val(bit_val),
    .rdata(rdata), .cmp_below(cmp_below), .irq_req(irq_req),
    .rst_req(rst_req), .ready(ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] v);
    wr_byte = 1'b1; wdata = v;
    step(1);
    wr_byte = 1'b0;
  endtask

  task automatic wbit(input logic [2:0] i, input logic v);
    wr_bit = 1'b1; bit_sel = i; bit_val = v;
    step(1);
    wr_bit = 1'b0;
  endtask

  task automatic do_reset(input logic cause);
    rst_by_lvd = cause; rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    rst_by_lvd = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1);
    do_reset(1'b0);
    // R1 reset state (one edge after release)
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", irq_req, 0);
    chk("R1 rst", rst_req, 0);
    chk("R1 ready", ready, 0);

    // R3: disabled flag ignores comparator
    cmp_below = 1'b1;
    step(3);
    chk("R3 flag off", rdata, 8'h00);

    // R2/R4/R8: exhaustive byte writes, comparator low-supply
    for (int v = 0; v < 256; v++) begin
      wbyte(8'h00);
      wbyte(v[7:0]);
      chk("R2 readback", rdata, {v[7], 5'b0, v[1], v[7]});
      chk("R8 no req unsettled", {irq_req, rst_req}, 2'b00);
    end

    // R10/R2: single-bit writes
    for (int i = 0; i < 8; i++) begin
      wbyte(8'h00);
      wbit(i[2:0], 1'b1);
      chk("R10 bit set", rdata, (i == 7) ? 8'h81 : (i == 1) ? 8'h02 : 8'h00);
      wbyte(8'h82);
      wbit(i[2:0], 1'b0);
      chk("R10 bit clr", rdata, (i == 7) ? 8'h02 : (i == 1) ? 8'h81 : 8'h83);
    end

    // R5/R6/R4: settling and interrupt for both comparator levels
    for (int b = 0; b < 2; b++) begin
      wbyte(8'h00);
      cmp_below = b[0];
      step(3);
      wbyte(8'h80);
      step(S - 1);
      chk("R5 not ready", ready, 0);
      chk("R8 irq low", irq_req, 0);
      step(1);
      chk("R5 ready", ready, 1);
      chk("R6 irq level", irq_req, b[0]);
      chk("R4 flag", rdata[0], b[0]);
      cmp_below = 1'b0;
      step(1);
      chk("R4 sync delay", rdata[0], b[0]);
      step(1);
      chk("R4 flag drop", rdata[0], 0);
      chk("R6 irq drop", irq_req, 0);
      wbit(3'd7, 1'b0);
      chk("R5 ready drop", ready, 0);
    end

    // R7: reset pulse
    cmp_below = 1'b1;
    wbyte(8'h00);
    step(3);
    wbyte(8'h82);
    step(S);
    chk("R7 ready", ready, 1);
    chk("R7 not yet", rst_req, 0);
    step(1);
    chk("R7 pulse start", rst_req, 1);
    chk("R6 no irq mode1", irq_req, 0);
    for (int k = 1; k < P; k++) begin
      step(1);
      chk("R7 pulse hold", rst_req, 1);
    end
    step(1);
    chk("R7 pulse end", rst_req, 0);

    // R9: detector-caused reset keeps bits; R8 settling after it
    do_reset(1'b1);
    chk("R9 kept", rdata & 8'hFE, 8'h82);
    chk("R8 ready after lvd rst", ready, 0);
    for (int k = 1; k < S; k++) begin
      step(1);
      chk("R8 no rst while settling", rst_req, 0);
    end
    step(1);
    chk("R5 ready after lvd rst", ready, 1);
    step(1);
    chk("R7 pulse after lvd rst", rst_req, 1);

    // R11: byte 0x00 aborts pulse
    wbyte(8'h00);
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 rst", rst_req, 0);
    chk("R11 ready", ready, 0);
    wbyte(8'h80);
    step(S);
    chk("R6 irq on", irq_req, 1);
    wbyte(8'h00);
    chk("R11 irq", irq_req, 0);

    // R10: clear enable by bit while mode=1, no spurious pulse
    wbyte(8'h82);
    step(S);
    wbit(3'd7, 1'b0);
    for (int k = 0; k < 2 * P; k++) begin
      chk("R10 no pulse", rst_req, 0);
      chk("R10 mode kept", rdata, 8'h02);
      step(1);
    end

    // R9/R1: other reset clears
    wbyte(8'h82);
    do_reset(1'b0);
    chk("R9 cleared", rdata, 8'h00);
    chk("R1 ready", ready, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule